// File: doc/BRIEF.md
# PLL Power Sequencer

This block walks a PLL and its downstream clock path through a fixed power-up and power-down order, one control bit at a time. On a start request it first waits for the reference generator to report ready. It then enables the PLL bias, waits a settle interval and starts the PLL core. Next it polls the lock status at fixed microsecond intervals. Once lock is seen it opens the global clock gate and enables the resync FIFO, and finally raises a done flag. A stop request, accepted only while the block is fully up, runs the path down in reverse. The clock gate is closed before anything is powered off.

When the paired mode input is high at the start request, the sequencer also drives a second (slave) instance's bias, clock gate and FIFO controls, each right after the matching local step. If either poll runs out of time, the sequencer raises an error flag and leaves the clock path closed. The next start request clears the error and tries again. All delays are measured in pulses of a microsecond tick input. Sub-microsecond settle waits are rounded up to whole ticks.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset every control output, done and error are 0.
- R2: A start request first polls `ref_ready` (once on entry, then every REF_POLL_US ticks). The bias is never raised unless `ref_ready` was seen. If `ref_ready` is not seen by the poll that falls REF_TIMEOUT_US ticks after entry, error is set and all controls stay 0.
- R3: Power-up changes exactly one output per step, in the order bias, slave bias, core start, clock gate, slave clock gate, FIFO, slave FIFO, done. Slave steps are present only in paired mode.
- R4: The clock gate is never open while the core start bit is clear.
- R5: Lock is sampled once when the core starts and then every LOCK_POLL_US ticks. The clock gate therefore opens a whole number of poll intervals after the core start.
- R6: If lock is not seen by the poll LOCK_TIMEOUT_US ticks after the core start, error is set. Core start and both bias bits are cleared, and the clock gate and FIFO stay closed.
- R7: A stop clears, one step at a time: done, clock gate, core start, FIFO, bias. After BIAS_WAIT_TICKS ticks, paired mode continues with slave gate, slave FIFO and slave bias.
- R8: With the paired mode input low at the start request, the slave outputs stay 0 for the whole sequence.
- R9: A start request is ignored while a sequence is in progress or the block is up. A stop request is ignored except when done is high.
- R10: A start request while error is high clears error and runs a fresh power-up.
- R11: Core start rises at least BIAS_WAIT_TICKS ticks after the last bias bit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start_req | input | 1 | Power-up request pulse |
| stop_req | input | 1 | Power-down request pulse |
| master_mode | input | 1 | Also sequence the slave instance; sampled at start |
| ref_ready | input | 1 | Reference generator ready status |
| pll_lock | input | 1 | PLL lock status |
| bias_en | output | 1 | Local PLL bias enable |
| slv_bias_en | output | 1 | Slave PLL bias enable |
| core_start | output | 1 | PLL core start |
| clk_gate_en | output | 1 | Local global clock gate open |
| slv_clk_gate_en | output | 1 | Slave global clock gate open |
| fifo_en | output | 1 | Local resync FIFO enable |
| slv_fifo_en | output | 1 | Slave resync FIFO enable |
| done | output | 1 | Path fully up |
| error | output | 1 | A poll timed out |

## Verification
The hardest cases to reach from the ports are the timeout paths, where nothing ever changes on the status inputs. They are also the exact poll instants at which lock is first noticed. The bench runs the block with short poll intervals and timeouts, and it counts microsecond ticks at every output change. Lock is withheld for a whole run to force a lock timeout measured in ticks. It is raised part way between two polls to show that the gate waits for the next poll point. The reference input is held low to reach the earlier abort.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [4:0] {
      ST_IDLE,
      ST_REF,
      ST_SBIAS,
      ST_BWAIT,
      ST_LOCK,
      ST_SGATE,
      ST_FIFO,
      ST_SFIFO,
      ST_FIN,
      ST_RUN,
      ST_D_GATE,
      ST_D_CORE,
      ST_D_FIFO,
      ST_D_BIAS,
      ST_D_BWAIT,
      ST_D_SGATE,
      ST_D_SFIFO,
      ST_D_SBIAS,
      ST_D_SWAIT,
      ST_ERR
   } seq_state_t;

endpackage

// File: rtl/pll_poll_unit.sv
module pll_poll_unit #(
   parameter int POLL_US    = 100,
   parameter int TIMEOUT_US = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic us_tick,
   input  logic status,
   output logic hit,
   output logic expire
);
   localparam int MAXPOLL = TIMEOUT_US / POLL_US;
   localparam int CW      = $clog2(POLL_US + 1);
   localparam int PW      = $clog2(MAXPOLL + 1);

   initial begin
      if (POLL_US < 1) $fatal(1, "poll interval must be at least one tick");
      if (TIMEOUT_US % POLL_US != 0) $fatal(1, "timeout must be a multiple of the poll interval");
   end

   logic          run_q;
   logic          pnow_q;
   logic [CW-1:0] cnt_q;
   logic [PW-1:0] npoll_q;

   assign hit    = run_q && pnow_q && status;
   assign expire = run_q && pnow_q && !status && (npoll_q == PW'(MAXPOLL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         pnow_q  <= 1'b0;
         cnt_q   <= '0;
         npoll_q <= '0;
      end else if (arm) begin
         run_q   <= 1'b1;
         pnow_q  <= 1'b1;
         cnt_q   <= '0;
         npoll_q <= '0;
      end else if (run_q) begin
         if (hit || expire) begin
            run_q  <= 1'b0;
            pnow_q <= 1'b0;
         end else begin
            if (pnow_q) begin
               npoll_q <= npoll_q + 1'b1;
               pnow_q  <= 1'b0;
            end
            if (us_tick) begin
               if (cnt_q == CW'(POLL_US - 1)) begin
                  cnt_q  <= '0;
                  pnow_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end

   // R5: the poll count never runs past the timeout budget
   a_r5_poll_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (npoll_q <= PW'(MAXPOLL)));

   // R5: between poll points the tick counter stays below the interval
   a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q < CW'(POLL_US)));

endmodule

// File: rtl/pll_tick_delay.sv
module pll_tick_delay #(
   parameter int WAIT_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic us_tick,
   output logic fin
);
   localparam int CW = $clog2(WAIT_TICKS + 1);

   initial begin
      if (WAIT_TICKS < 1) $fatal(1, "settle wait must be at least one tick");
   end

   logic          run_q;
   logic [CW-1:0] cnt_q;

   assign fin = run_q && (cnt_q == CW'(WAIT_TICKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (arm) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end else if (fin) begin
         run_q <= 1'b0;
      end else if (run_q && us_tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R11: the wait counter never passes its target
   a_r11_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= CW'(WAIT_TICKS)));

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
   import pll_seq_pkg::*;
#(
   parameter int REF_POLL_US     = 5,
   parameter int REF_TIMEOUT_US  = 1000,
   parameter int LOCK_POLL_US    = 100,
   parameter int LOCK_TIMEOUT_US = 5000,
   parameter int BIAS_WAIT_TICKS = 1,
   parameter bit SLAVE_EN        = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic us_tick,
   input  logic start_req,
   input  logic stop_req,
   input  logic master_mode,
   input  logic ref_ready,
   input  logic pll_lock,
   output logic bias_en,
   output logic slv_bias_en,
   output logic core_start,
   output logic clk_gate_en,
   output logic slv_clk_gate_en,
   output logic fifo_en,
   output logic slv_fifo_en,
   output logic done,
   output logic error
);

   seq_state_t st_q;
   logic start_acc;
   logic mst;
   logic ref_hit, ref_exp, lock_hit, lock_exp, dly_fin;
   logic arm_ref, arm_lock, arm_dly;

   assign start_acc = start_req && (st_q == ST_IDLE || st_q == ST_ERR);

   generate
      if (SLAVE_EN) begin : g_slave
         logic mst_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         mst_q <= 1'b0;
            else if (start_acc) mst_q <= master_mode;
         end
         assign mst = mst_q;

         // R8: slave controls stay low unless paired mode was latched
         a_r8_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !mst_q |-> !(slv_bias_en || slv_clk_gate_en || slv_fifo_en));
      end else begin : g_noslave
         assign mst = 1'b0;
      end
   endgenerate

   assign arm_ref  = start_acc;
   assign arm_lock = (st_q == ST_BWAIT) && dly_fin;
   assign arm_dly  = ((st_q == ST_REF) && ref_hit && !mst) || (st_q == ST_SBIAS) ||
                     (st_q == ST_D_BIAS) || (st_q == ST_D_SBIAS);

   pll_poll_unit #(.POLL_US(REF_POLL_US), .TIMEOUT_US(REF_TIMEOUT_US)) u_ref_poll (
      .clk(clk), .rst_n(rst_n), .arm(arm_ref), .us_tick(us_tick),
      .status(ref_ready), .hit(ref_hit), .expire(ref_exp)
   );

   pll_poll_unit #(.POLL_US(LOCK_POLL_US), .TIMEOUT_US(LOCK_TIMEOUT_US)) u_lock_poll (
      .clk(clk), .rst_n(rst_n), .arm(arm_lock), .us_tick(us_tick),
      .status(pll_lock), .hit(lock_hit), .expire(lock_exp)
   );

   pll_tick_delay #(.WAIT_TICKS(BIAS_WAIT_TICKS)) u_settle (
      .clk(clk), .rst_n(rst_n), .arm(arm_dly), .us_tick(us_tick), .fin(dly_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q            <= ST_IDLE;
         bias_en         <= 1'b0;
         slv_bias_en     <= 1'b0;
         core_start      <= 1'b0;
         clk_gate_en     <= 1'b0;
         slv_clk_gate_en <= 1'b0;
         fifo_en         <= 1'b0;
         slv_fifo_en     <= 1'b0;
         done            <= 1'b0;
         error           <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_ERR: if (start_acc) begin
               error <= 1'b0;
               st_q  <= ST_REF;
            end
            ST_REF: begin
               if (ref_hit) begin
                  bias_en <= 1'b1;
                  st_q    <= mst ? ST_SBIAS : ST_BWAIT;
               end else if (ref_exp) begin
                  error <= 1'b1;
                  st_q  <= ST_ERR;
               end
            end
            ST_SBIAS: begin
               slv_bias_en <= 1'b1;
               st_q        <= ST_BWAIT;
            end
            ST_BWAIT: if (dly_fin) begin
               core_start <= 1'b1;
               st_q       <= ST_LOCK;
            end
            ST_LOCK: begin
               if (lock_hit) begin
                  clk_gate_en <= 1'b1;
                  st_q        <= mst ? ST_SGATE : ST_FIFO;
               end else if (lock_exp) begin
                  error       <= 1'b1;
                  core_start  <= 1'b0;
                  bias_en     <= 1'b0;
                  slv_bias_en <= 1'b0;
                  st_q        <= ST_ERR;
               end
            end
            ST_SGATE: begin
               slv_clk_gate_en <= 1'b1;
               st_q            <= ST_FIFO;
            end
            ST_FIFO: begin
               fifo_en <= 1'b1;
               st_q    <= mst ? ST_SFIFO : ST_FIN;
            end
            ST_SFIFO: begin
               slv_fifo_en <= 1'b1;
               st_q        <= ST_FIN;
            end
            ST_FIN: begin
               done <= 1'b1;
               st_q <= ST_RUN;
            end
            ST_RUN: if (stop_req) begin
               done <= 1'b0;
               st_q <= ST_D_GATE;
            end
            ST_D_GATE: begin
               clk_gate_en <= 1'b0;
               st_q        <= ST_D_CORE;
            end
            ST_D_CORE: begin
               core_start <= 1'b0;
               st_q       <= ST_D_FIFO;
            end
            ST_D_FIFO: begin
               fifo_en <= 1'b0;
               st_q    <= ST_D_BIAS;
            end
            ST_D_BIAS: begin
               bias_en <= 1'b0;
               st_q    <= ST_D_BWAIT;
            end
            ST_D_BWAIT: if (dly_fin) st_q <= mst ? ST_D_SGATE : ST_IDLE;
            ST_D_SGATE: begin
               slv_clk_gate_en <= 1'b0;
               st_q            <= ST_D_SFIFO;
            end
            ST_D_SFIFO: begin
               slv_fifo_en <= 1'b0;
               st_q        <= ST_D_SBIAS;
            end
            ST_D_SBIAS: begin
               slv_bias_en <= 1'b0;
               st_q        <= ST_D_SWAIT;
            end
            ST_D_SWAIT: if (dly_fin) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R4: gate open implies the core is running
   a_r4_gate_needs_core: assert property (@(posedge clk) disable iff (!rst_n)
      clk_gate_en |-> core_start);

   // R3: the FIFO only comes up behind an open gate
   a_r3_fifo_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_en) |-> clk_gate_en);

   // R3: done only with the whole local path up
   a_r3_done_all_up: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bias_en && core_start && clk_gate_en && fifo_en));

   // R6: error leaves the clock path closed
   a_r6_error_closed: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !(clk_gate_en || fifo_en || slv_clk_gate_en || slv_fifo_en || done));

   // R2: bias rises only after the reference was reported ready
   a_r2_bias_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bias_en) |-> $past(ref_ready));

   // R7: bias drops only after gate and core are off
   a_r7_bias_off_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bias_en) && !error |-> !(core_start || clk_gate_en || fifo_en));

endmodule

// File: tb/sim_pll_pwr_seq.sv
module sim_pll_pwr_seq;

   localparam int LPOLL = 4;
   localparam int LTO   = 20;
   localparam int RPOLL = 2;
   localparam int RTO   = 10;
   localparam int BWAIT = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic us_tick = 1'b0;
   logic start_req = 1'b0, stop_req = 1'b0, master_mode = 1'b0;
   logic ref_ready = 1'b0, pll_lock = 1'b0;
   logic bias_en, slv_bias_en, core_start, clk_gate_en, slv_clk_gate_en;
   logic fifo_en, slv_fifo_en, done, error;

   always #4 clk = ~clk;

   pll_pwr_seq #(
      .REF_POLL_US(RPOLL), .REF_TIMEOUT_US(RTO),
      .LOCK_POLL_US(LPOLL), .LOCK_TIMEOUT_US(LTO),
      .BIAS_WAIT_TICKS(BWAIT), .SLAVE_EN(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start_req(start_req),
      .stop_req(stop_req), .master_mode(master_mode), .ref_ready(ref_ready),
      .pll_lock(pll_lock), .bias_en(bias_en), .slv_bias_en(slv_bias_en),
      .core_start(core_start), .clk_gate_en(clk_gate_en),
      .slv_clk_gate_en(slv_clk_gate_en), .fifo_en(fifo_en),
      .slv_fifo_en(slv_fifo_en), .done(done), .error(error)
   );

   // vector: [8]error [7]done [6]sfifo [5]fifo [4]sgate [3]gate [2]core [1]sbias [0]bias
   logic [8:0] vec;
   assign vec = {error, done, slv_fifo_en, fifo_en, slv_clk_gate_en,
                 clk_gate_en, core_start, slv_bias_en, bias_en};

   typedef struct {
      logic [8:0] v;
      string      tag;
   } exp_t;

   exp_t       expq[$];
   int         checks = 0;
   int         errors = 0;
   int         tick_no = 0;
   int         t_bias = 0, t_core = 0, t_gate = 0, t_err = 0;
   logic [8:0] prev = '0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [8:0] v, input string tag);
      exp_t e;
      e.v = v;
      e.tag = tag;
      expq.push_back(e);
   endtask

   // tick generator: one-cycle pulse every 4 clocks
   initial begin
      forever begin
         repeat (3) @(posedge clk);
         #1 us_tick = 1'b1;
         @(posedge clk);
         #1 us_tick = 1'b0;
      end
   end

   // monitor: pops expected vectors as outputs change
   always @(negedge clk) begin
      if (rst_n) begin
         if (vec !== prev) begin
            if (expq.size() == 0) begin
               check(1'b0, "R9 unexpected output change", int'(vec), int'(prev));
            end else begin
               exp_t e;
               e = expq.pop_front();
               check(vec === e.v, e.tag, int'(vec), int'(e.v));
            end
            if (vec[0] && !prev[0]) t_bias = tick_no;
            if (vec[1] && !prev[1]) t_bias = tick_no;
            if (vec[2] && !prev[2]) t_core = tick_no;
            if (vec[3] && !prev[3]) t_gate = tick_no;
            if (vec[8] && !prev[8]) t_err  = tick_no;
         end
         prev = vec;
         if (us_tick) tick_no++;
      end
   end

   task automatic pulse_start();
      @(posedge clk); #1 start_req = 1'b1;
      @(posedge clk); #1 start_req = 1'b0;
   endtask

   task automatic pulse_stop();
      @(posedge clk); #1 stop_req = 1'b1;
      @(posedge clk); #1 stop_req = 1'b0;
   endtask

   task automatic drain(input string req);
      int n;
      n = 0;
      while (expq.size() != 0 && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check(expq.size() == 0, req, expq.size(), 0);
      expq.delete();
      repeat (3) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int t_start;
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      check(vec == 9'h000, "R1 reset outputs", int'(vec), 0);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // paired power-up, R3 R2 R4 R5 R11, with ignored requests mid-way (R9)
      master_mode = 1'b1; ref_ready = 1'b1; pll_lock = 1'b0;
      push(9'h001, "R3 bias"); push(9'h003, "R3 slave bias");
      push(9'h007, "R3 R11 core start"); push(9'h00F, "R3 R4 gate");
      push(9'h01F, "R3 slave gate"); push(9'h03F, "R3 fifo");
      push(9'h07F, "R3 slave fifo"); push(9'h0FF, "R3 done");
      pulse_start();
      while (!core_start) @(negedge clk);
      pulse_start();
      pulse_stop();
      repeat (22) @(posedge clk);
      #1 pll_lock = 1'b1;
      drain("R3 power-up sequence");
      check((t_gate - t_core) % LPOLL == 0 && t_gate > t_core, "R5 gate on poll point",
            t_gate - t_core, LPOLL);
      check(t_core - t_bias >= BWAIT, "R11 bias settle", t_core - t_bias, BWAIT);

      // R9: start while up has no effect
      pulse_start();
      repeat (40) @(negedge clk);
      check(vec == 9'h0FF, "R9 start ignored while up", int'(vec), 9'h0FF);

      // R7: paired power-down
      push(9'h07F, "R7 done off"); push(9'h077, "R7 gate off");
      push(9'h073, "R7 core off"); push(9'h053, "R7 fifo off");
      push(9'h052, "R7 bias off"); push(9'h042, "R7 slave gate off");
      push(9'h002, "R7 slave fifo off"); push(9'h000, "R7 slave bias off");
      pulse_stop();
      drain("R7 power-down sequence");
      // R9: stop while idle has no effect
      pulse_stop();
      repeat (20) @(negedge clk);
      check(vec == 9'h000, "R9 stop ignored when idle", int'(vec), 0);

      // R8: standalone up and down
      master_mode = 1'b0;
      push(9'h001, "R8 bias"); push(9'h005, "R8 core"); push(9'h00D, "R8 gate");
      push(9'h02D, "R8 fifo"); push(9'h0AD, "R8 done");
      pulse_start();
      drain("R8 standalone up");
      push(9'h02D, "R8 done off"); push(9'h025, "R8 gate off");
      push(9'h021, "R8 core off"); push(9'h001, "R8 fifo off"); push(9'h000, "R8 bias off");
      pulse_stop();
      drain("R8 standalone down");

      // R6: lock timeout
      pll_lock = 1'b0; master_mode = 1'b1;
      push(9'h001, "R6 bias"); push(9'h003, "R6 slave bias");
      push(9'h007, "R6 core"); push(9'h100, "R6 error, path closed");
      pulse_start();
      drain("R6 timeout sequence");
      check(t_err - t_core == LTO, "R6 timeout length", t_err - t_core, LTO);

      // R10: retry from error clears it
      pll_lock = 1'b1; master_mode = 1'b0;
      push(9'h000, "R10 error cleared"); push(9'h001, "R10 bias");
      push(9'h005, "R10 core"); push(9'h00D, "R10 gate");
      push(9'h02D, "R10 fifo"); push(9'h0AD, "R10 done");
      pulse_start();
      drain("R10 retry sequence");
      push(9'h02D, "R10 done off"); push(9'h025, "R10 gate off");
      push(9'h021, "R10 core off"); push(9'h001, "R10 fifo off"); push(9'h000, "R10 bias off");
      pulse_stop();
      drain("R10 retry down");

      // R2: reference never ready
      ref_ready = 1'b0;
      push(9'h100, "R2 ref timeout error");
      t_start = tick_no;
      pulse_start();
      drain("R2 ref abort");
      check(t_err - t_start >= RTO, "R2 ref timeout length", t_err - t_start, RTO);
      repeat (20) @(negedge clk);
      check(vec == 9'h100, "R2 no bias without ref", int'(vec), 9'h100);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule